// File: doc/BRIEF.md
# Transfer Negotiation Parameter Table

This block sits beside a parallel bus repeater and listens to the message bytes that initiators and targets exchange. It picks out the two extended negotiation messages, the one that agrees a synchronous period and offset and the one that agrees a data width. It keeps the agreed values per target ID in a small on-chip table. Nothing is ever sent on the bus. The table only records what other devices agree. A value is committed only when one side has sent a request and the other side has answered within the same connection.

The retiming logic reads the table with a registered lookup by target ID. A target that has no agreed synchronous entry reads back a fixed fast-20 setting. The fast-40 period can therefore only come back from a completed negotiation. Entries survive from one connection to the next. They are lost only on chip reset or a received bus reset, and a later negotiation for the same target overwrites them.

The message input is a valid/ready stream. Ready is high exactly while a connection is open and no bus reset is present. A byte counts as taken only in a cycle where valid and ready are both high. The source cannot stall the bus, so it simply drops any byte it offers while ready is low. Bus phase decoding and the current target ID are supplied by the surrounding logic.

Top module: `nt_xfer_table`

## Requirements
- R1: An extended message is the byte 0x01, then a length byte, then a code byte. The synchronous message has code 0x01 and length 3, and its two argument bytes are the period and then the offset. The width message has code 0x03 and length 2, and its one argument is the width exponent. Any other code or length is skipped over by its length and has no effect.
- R2: An entry is written only when a message of one kind from one side (`msg_from_tgt_i` = 0 for initiator, 1 for target) is followed by a message of the same kind from the other side, for the current target, within one connection. The values of that second message (the response) are stored.
- R3: A target with no synchronous entry reads back `lk_negotiated_o` = 0, period `DEF_PERIOD` (default 12, i.e. fast-20) and offset `DEF_OFFSET` (default 8).
- R4: A period below `DEF_PERIOD` (for example 10, fast-40) appears on the lookup only together with `lk_negotiated_o` = 1.
- R5: A bus reset (`bus_rst_i` high) clears every entry to the not-negotiated, narrow state and discards any half-finished negotiation.
- R6: When the connection closes (`conn_active_i` low), a negotiation that has only one side is discarded.
- R7: Entries persist across connections. A new completed negotiation overwrites only the fields of that target, and the entries of other targets stay unchanged.
- R8: Lookup latency is one cycle. The outputs after a clock edge describe the `lk_id_i` sampled at that edge, and a new ID may be presented every cycle.
- R9: A stored offset of 0 is reported as asynchronous: `lk_async_o` = 1 and `lk_offset_o` = 0.
- R10: A completed width negotiation with a nonzero exponent sets `lk_wide_o` = 1, and one with exponent 0 sets it to 0. A target that has never completed a width negotiation reads 0.
- R11: `msg_ready_o` is high exactly when `conn_active_i` is high and `bus_rst_i` is low. Bytes offered while it is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_rst_i | input | 1 | Bus reset seen on the bus |
| conn_active_i | input | 1 | A connection (nexus) is open |
| conn_tgt_i | input | ID_W | Target ID of the open connection |
| msg_valid_i | input | 1 | Message byte offered |
| msg_ready_o | output | 1 | Message byte can be taken |
| msg_byte_i | input | 8 | Message byte |
| msg_from_tgt_i | input | 1 | Byte sent by the target (1) or by the initiator (0) |
| lk_id_i | input | ID_W | Target ID to look up |
| lk_negotiated_o | output | 1 | A synchronous agreement is stored |
| lk_period_o | output | 8 | Transfer period factor |
| lk_offset_o | output | 8 | REQ/ACK offset |
| lk_async_o | output | 1 | Offset is zero, so transfers are asynchronous |
| lk_wide_o | output | 1 | 16-bit transfers agreed |

## Verification
The bench builds the block with its default parameters: a 4-bit ID (16 targets), default period 12 and default offset 8. With these values the highest target ID, 15, can be reached, and because the default offset is nonzero a stored zero offset can be told apart from the default. The bench scores fast-40 commits and renegotiation, ignored unknown and malformed extended messages placed between a request and its answer, partial negotiations cut off by a closing connection or a bus reset, and back-to-back lookups of different IDs.

// File: rtl/nt_pkg.sv
package nt_pkg;
  localparam int MSG_W = 8;

  localparam logic [MSG_W-1:0] EXT_MSG   = 8'h01;
  localparam logic [MSG_W-1:0] CODE_SYNC = 8'h01;
  localparam logic [MSG_W-1:0] CODE_WIDE = 8'h03;
  localparam logic [MSG_W-1:0] LEN_SYNC  = 8'd3;
  localparam logic [MSG_W-1:0] LEN_WIDE  = 8'd2;

  typedef enum logic [1:0] {EV_NONE, EV_SYNC, EV_WIDE} ev_kind_t;

  typedef struct packed {
    logic             sync_ok;
    logic [MSG_W-1:0] period;
    logic [MSG_W-1:0] offset;
    logic             is_async;
    logic             wide;
  } entry_t;
endpackage

// File: rtl/nt_msg_parser.sv
module nt_msg_parser
  import nt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             take,
  input  logic [MSG_W-1:0] byte_i,
  input  logic             from_tgt,
  output logic             ev_valid,
  output ev_kind_t         ev_kind,
  output logic             ev_from_tgt,
  output logic [MSG_W-1:0] ev_a0,
  output logic [MSG_W-1:0] ev_a1
);
  typedef enum logic [1:0] {P_IDLE, P_LEN, P_CODE, P_ARGS} pst_t;

  pst_t             st_q;
  logic [MSG_W-1:0] len_q, left_q, a0_q;
  ev_kind_t         kind_q;
  logic             idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= P_IDLE; len_q <= '0; left_q <= '0; a0_q <= '0;
      kind_q <= EV_NONE; idx_q <= 1'b0;
      ev_valid <= 1'b0; ev_kind <= EV_NONE; ev_from_tgt <= 1'b0;
      ev_a0 <= '0; ev_a1 <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (flush) begin
        st_q <= P_IDLE;
      end else if (take) begin
        case (st_q)
          P_IDLE: if (byte_i == EXT_MSG) st_q <= P_LEN;
          P_LEN: begin
            len_q <= byte_i;
            st_q  <= (byte_i == '0) ? P_IDLE : P_CODE;
          end
          P_CODE: begin
            if (byte_i == CODE_SYNC && len_q == LEN_SYNC)      kind_q <= EV_SYNC;
            else if (byte_i == CODE_WIDE && len_q == LEN_WIDE) kind_q <= EV_WIDE;
            else                                               kind_q <= EV_NONE;
            left_q <= len_q - 1'b1;
            idx_q  <= 1'b0;
            st_q   <= (len_q == 8'd1) ? P_IDLE : P_ARGS;
          end
          default: begin
            idx_q  <= 1'b1;
            if (!idx_q) a0_q <= byte_i;
            left_q <= left_q - 1'b1;
            if (left_q == 8'd1) begin
              st_q <= P_IDLE;
              if (kind_q != EV_NONE) begin
                ev_valid    <= 1'b1;
                ev_kind     <= kind_q;
                ev_from_tgt <= from_tgt;
                ev_a0       <= idx_q ? a0_q : byte_i;
                ev_a1       <= byte_i;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/nt_pair_tracker.sv
module nt_pair_tracker
  import nt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ev_valid,
  input  ev_kind_t         ev_kind,
  input  logic             ev_from_tgt,
  input  logic [MSG_W-1:0] ev_a0,
  input  logic [MSG_W-1:0] ev_a1,
  output logic             wr_sync,
  output logic             wr_wide,
  output logic [MSG_W-1:0] wr_period,
  output logic [MSG_W-1:0] wr_offset,
  output logic             wr_wide_bit
);
  logic pend_s_q, pend_s_dir_q, pend_w_q, pend_w_dir_q;
  logic is_s, is_w;

  always_comb begin
    is_s        = ev_valid && ev_kind == EV_SYNC && !flush;
    is_w        = ev_valid && ev_kind == EV_WIDE && !flush;
    wr_sync     = is_s && pend_s_q && (pend_s_dir_q != ev_from_tgt);
    wr_wide     = is_w && pend_w_q && (pend_w_dir_q != ev_from_tgt);
    wr_period   = ev_a0;
    wr_offset   = ev_a1;
    wr_wide_bit = (ev_a0 != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_s_q <= 1'b0; pend_s_dir_q <= 1'b0;
      pend_w_q <= 1'b0; pend_w_dir_q <= 1'b0;
    end else if (flush) begin
      pend_s_q <= 1'b0;
      pend_w_q <= 1'b0;
    end else begin
      if (is_s) begin
        pend_s_q     <= !wr_sync;
        pend_s_dir_q <= ev_from_tgt;
      end
      if (is_w) begin
        pend_w_q     <= !wr_wide;
        pend_w_dir_q <= ev_from_tgt;
      end
    end
  end
endmodule

// File: rtl/nt_param_table.sv
module nt_param_table
  import nt_pkg::*;
#(
  parameter int               ID_W       = 4,
  parameter logic [MSG_W-1:0] DEF_PERIOD = 8'd12,
  parameter logic [MSG_W-1:0] DEF_OFFSET = 8'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_sync,
  input  logic             wr_wide,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [MSG_W-1:0] wr_period,
  input  logic [MSG_W-1:0] wr_offset,
  input  logic             wr_wide_bit,
  input  logic [ID_W-1:0]  lk_id,
  output logic             lk_negotiated,
  output logic [MSG_W-1:0] lk_period,
  output logic [MSG_W-1:0] lk_offset,
  output logic             lk_async,
  output logic             lk_wide
);
  localparam int  N_IDS     = 1 << ID_W;
  localparam logic DEF_ASYNC = (DEF_OFFSET == '0);

  entry_t ent_q [N_IDS];
  entry_t rd;

  for (genvar g = 0; g < N_IDS; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (clear) begin
        ent_q[g] <= '0;
      end else begin
        if (wr_sync && wr_id == ID_W'(g)) begin
          ent_q[g].sync_ok  <= 1'b1;
          ent_q[g].period   <= wr_period;
          ent_q[g].offset   <= wr_offset;
          ent_q[g].is_async <= (wr_offset == '0);
        end
        if (wr_wide && wr_id == ID_W'(g)) ent_q[g].wide <= wr_wide_bit;
      end
    end
  end

  assign rd = ent_q[lk_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_negotiated <= 1'b0;
      lk_period     <= DEF_PERIOD;
      lk_offset     <= DEF_OFFSET;
      lk_async      <= DEF_ASYNC;
      lk_wide       <= 1'b0;
    end else begin
      lk_negotiated <= rd.sync_ok;
      lk_period     <= rd.sync_ok ? rd.period   : DEF_PERIOD;
      lk_offset     <= rd.sync_ok ? rd.offset   : DEF_OFFSET;
      lk_async      <= rd.sync_ok ? rd.is_async : DEF_ASYNC;
      lk_wide       <= rd.wide;
    end
  end
endmodule

// File: rtl/nt_xfer_table.sv
module nt_xfer_table
  import nt_pkg::*;
#(
  parameter int               ID_W       = 4,
  parameter logic [MSG_W-1:0] DEF_PERIOD = 8'd12,
  parameter logic [MSG_W-1:0] DEF_OFFSET = 8'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst_i,
  input  logic             conn_active_i,
  input  logic [ID_W-1:0]  conn_tgt_i,
  input  logic             msg_valid_i,
  output logic             msg_ready_o,
  input  logic [MSG_W-1:0] msg_byte_i,
  input  logic             msg_from_tgt_i,
  input  logic [ID_W-1:0]  lk_id_i,
  output logic             lk_negotiated_o,
  output logic [MSG_W-1:0] lk_period_o,
  output logic [MSG_W-1:0] lk_offset_o,
  output logic             lk_async_o,
  output logic             lk_wide_o
);
  logic             flush, take;
  logic             ev_valid, ev_from_tgt;
  ev_kind_t         ev_kind;
  logic [MSG_W-1:0] ev_a0, ev_a1;
  logic             wr_sync, wr_wide, wr_wide_bit;
  logic [MSG_W-1:0] wr_period, wr_offset;

  assign msg_ready_o = conn_active_i && !bus_rst_i;
  assign take        = msg_valid_i && msg_ready_o;
  assign flush       = bus_rst_i || !conn_active_i;

  nt_msg_parser u_parser (
    .clk, .rst_n, .flush, .take,
    .byte_i(msg_byte_i), .from_tgt(msg_from_tgt_i),
    .ev_valid, .ev_kind, .ev_from_tgt, .ev_a0, .ev_a1
  );

  nt_pair_tracker u_track (
    .clk, .rst_n, .flush,
    .ev_valid, .ev_kind, .ev_from_tgt, .ev_a0, .ev_a1,
    .wr_sync, .wr_wide, .wr_period, .wr_offset, .wr_wide_bit
  );

  nt_param_table #(.ID_W(ID_W), .DEF_PERIOD(DEF_PERIOD), .DEF_OFFSET(DEF_OFFSET)) u_table (
    .clk, .rst_n, .clear(bus_rst_i),
    .wr_sync, .wr_wide, .wr_id(conn_tgt_i),
    .wr_period, .wr_offset, .wr_wide_bit,
    .lk_id(lk_id_i),
    .lk_negotiated(lk_negotiated_o), .lk_period(lk_period_o),
    .lk_offset(lk_offset_o), .lk_async(lk_async_o), .lk_wide(lk_wide_o)
  );
endmodule

// File: rtl/nt_xfer_table_chk.sv
module nt_xfer_table_chk #(
  parameter logic [7:0] DEF_PERIOD = 8'd12,
  parameter logic [7:0] DEF_OFFSET = 8'd8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst_i,
  input logic       conn_active_i,
  input logic       msg_ready_o,
  input logic       lk_negotiated_o,
  input logic [7:0] lk_period_o,
  input logic [7:0] lk_offset_o,
  input logic       lk_async_o,
  input logic       lk_wide_o
);
  p_ready_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!conn_active_i || bus_rst_i) |-> !msg_ready_o);

  p_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_negotiated_o |-> (lk_period_o == DEF_PERIOD && lk_offset_o == DEF_OFFSET));

  p_fast_needs_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_period_o < DEF_PERIOD) |-> lk_negotiated_o);

  p_async_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_async_o == (lk_offset_o == 8'd0));

  p_bus_reset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rst_i) && $past(bus_rst_i, 2)) |-> (!lk_negotiated_o && !lk_wide_o));
endmodule

bind nt_xfer_table nt_xfer_table_chk #(.DEF_PERIOD(DEF_PERIOD), .DEF_OFFSET(DEF_OFFSET)) u_chk (
  .clk, .rst_n, .bus_rst_i, .conn_active_i, .msg_ready_o,
  .lk_negotiated_o, .lk_period_o, .lk_offset_o, .lk_async_o, .lk_wide_o
);

// File: tb/test_nt_xfer_table.sv
module test_nt_xfer_table;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0, conn = 1'b0, mvalid = 1'b0, mtgt = 1'b0;
  logic [3:0] ctgt = '0, lk_id = '0;
  logic [7:0] mbyte = '0;
  logic       mready, lk_neg, lk_async, lk_wide;
  logic [7:0] lk_per, lk_off;

  always #5 clk = ~clk;

  nt_xfer_table i_nt_xfer_table (
    .clk, .rst_n, .bus_rst_i(bus_rst), .conn_active_i(conn), .conn_tgt_i(ctgt),
    .msg_valid_i(mvalid), .msg_ready_o(mready), .msg_byte_i(mbyte),
    .msg_from_tgt_i(mtgt), .lk_id_i(lk_id),
    .lk_negotiated_o(lk_neg), .lk_period_o(lk_per), .lk_offset_o(lk_off),
    .lk_async_o(lk_async), .lk_wide_o(lk_wide)
  );

  typedef struct {
    int         due;
    string      tag;
    logic       neg;
    logic [7:0] per, off;
    logic       as, wd;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, n_cmp = 0, n_bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares lookup results against the scoreboard queue
  always @(negedge clk) begin : mon
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      n_cmp++;
      if ({lk_neg, lk_per, lk_off, lk_async, lk_wide} !== {e.neg, e.per, e.off, e.as, e.wd}) begin
        n_bad++;
        $display("FAIL %s: got neg=%0b per=%0d off=%0d async=%0b wide=%0b, expected neg=%0b per=%0d off=%0d async=%0b wide=%0b",
                 e.tag, lk_neg, lk_per, lk_off, lk_async, lk_wide, e.neg, e.per, e.off, e.as, e.wd);
      end
    end
  end

  task automatic look(input logic [3:0] id, input logic neg, input logic [7:0] per,
                      input logic [7:0] off, input logic as, input logic wd, input string tag);
    exp_t e;
    @(negedge clk);
    lk_id = id;
    e.due = cyc + 1; e.tag = tag; e.neg = neg; e.per = per; e.off = off; e.as = as; e.wd = wd;
    q.push_back(e);
  endtask

  task automatic look_def(input logic [3:0] id, input string tag);
    look(id, 1'b0, 8'd12, 8'd8, 1'b0, 1'b0, tag);
  endtask

  task automatic chk_ready(input logic exp, input string tag);
    #1;
    n_cmp++;
    if (mready !== exp) begin
      n_bad++;
      $display("FAIL %s: got ready=%0b, expected %0b", tag, mready, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic t);
    @(negedge clk);
    mvalid = 1'b1; mbyte = b; mtgt = t;
  endtask

  task automatic quiet();
    @(negedge clk);
    mvalid = 1'b0;
  endtask

  task automatic sync_msg(input logic [7:0] per, input logic [7:0] off, input logic t);
    put(8'h01, t); put(8'h03, t); put(8'h01, t); put(per, t); put(off, t);
  endtask

  task automatic wide_msg(input logic [7:0] ex, input logic t);
    put(8'h01, t); put(8'h02, t); put(8'h03, t); put(ex, t);
  endtask

  task automatic open_conn(input logic [3:0] t);
    @(negedge clk);
    conn = 1'b1; ctgt = t;
  endtask

  task automatic close_conn();
    @(negedge clk);
    conn = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look_def(4'd0, "R3 default after reset");

    // R11: no connection, bytes must be ignored
    ctgt = 4'd10;
    chk_ready(1'b0, "R11 ready low without connection");
    sync_msg(8'd10, 8'd16, 1'b0); sync_msg(8'd10, 8'd16, 1'b1); quiet();
    look_def(4'd10, "R11 bytes ignored while not ready");

    // R2 / R4: fast-40 commit, response values stored
    open_conn(4'd3);
    chk_ready(1'b1, "R11 ready high in connection");
    sync_msg(8'd10, 8'h1F, 1'b0); sync_msg(8'd10, 8'h10, 1'b1); quiet();
    look(4'd3, 1'b1, 8'd10, 8'd16, 1'b0, 1'b0, "R2 R4 fast-40 committed with response offset");
    look_def(4'd4, "R7 other target untouched");
    wide_msg(8'd1, 1'b0); wide_msg(8'd1, 1'b1); quiet();
    look(4'd3, 1'b1, 8'd10, 8'd16, 1'b0, 1'b1, "R10 wide agreed");
    close_conn();

    // R6: one-sided negotiation lost at connection end
    open_conn(4'd5);
    sync_msg(8'd12, 8'd8, 1'b0); quiet();
    close_conn();
    open_conn(4'd5);
    sync_msg(8'd11, 8'd7, 1'b1); quiet();
    look_def(4'd5, "R6 half negotiation discarded at close");
    close_conn();

    // R1: unknown and malformed extended messages skipped
    open_conn(4'd6);
    sync_msg(8'd25, 8'd5, 1'b0);
    put(8'h01, 1'b1); put(8'h02, 1'b1); put(8'h04, 1'b1); put(8'h01, 1'b1);
    sync_msg(8'd25, 8'd5, 1'b1); quiet();
    look(4'd6, 1'b1, 8'd25, 8'd5, 1'b0, 1'b0, "R1 unknown message skipped by length");
    put(8'h01, 1'b0); put(8'h02, 1'b0); put(8'h01, 1'b0); put(8'h0B, 1'b0);
    put(8'h01, 1'b1); put(8'h02, 1'b1); put(8'h01, 1'b1); put(8'h0B, 1'b1);
    quiet();
    look(4'd6, 1'b1, 8'd25, 8'd5, 1'b0, 1'b0, "R1 wrong length ignored");
    close_conn();

    // R9: zero offset is asynchronous, highest ID
    open_conn(4'd15);
    sync_msg(8'd10, 8'd0, 1'b0); sync_msg(8'd10, 8'd0, 1'b1); quiet();
    look(4'd15, 1'b1, 8'd10, 8'd0, 1'b1, 1'b0, "R9 zero offset async");
    close_conn();

    // R7: target-initiated renegotiation overwrites
    open_conn(4'd3);
    sync_msg(8'd25, 8'd8, 1'b1); sync_msg(8'd25, 8'd8, 1'b0); quiet();
    look(4'd3, 1'b1, 8'd25, 8'd8, 1'b0, 1'b1, "R7 renegotiation overwrites, width kept");
    close_conn();

    // R8: back-to-back lookups
    look(4'd3, 1'b1, 8'd25, 8'd8, 1'b0, 1'b1, "R8 back-to-back id 3");
    look(4'd15, 1'b1, 8'd10, 8'd0, 1'b1, 1'b0, "R8 back-to-back id 15");
    look_def(4'd0, "R8 back-to-back id 0");
    look(4'd6, 1'b1, 8'd25, 8'd5, 1'b0, 1'b0, "R8 back-to-back id 6");

    // R10: narrow after wide
    open_conn(4'd8);
    wide_msg(8'd1, 1'b0); wide_msg(8'd1, 1'b1); quiet();
    look(4'd8, 1'b0, 8'd12, 8'd8, 1'b0, 1'b1, "R10 wide without sync entry");
    wide_msg(8'd0, 1'b1); wide_msg(8'd0, 1'b0); quiet();
    look_def(4'd8, "R10 exponent zero gives narrow");
    close_conn();

    // R5: bus reset clears table and partial negotiation
    open_conn(4'd9);
    sync_msg(8'd10, 8'd4, 1'b0); quiet();
    @(negedge clk); bus_rst = 1'b1;
    chk_ready(1'b0, "R11 ready low during bus reset");
    @(negedge clk); @(negedge clk); bus_rst = 1'b0;
    sync_msg(8'd10, 8'd4, 1'b1); quiet();
    look_def(4'd9, "R5 partial discarded by bus reset");
    look_def(4'd3, "R5 entry 3 cleared");
    look_def(4'd15, "R5 entry 15 cleared");
    close_conn();

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule